// File: doc/BRIEF.md
# SPI Command Parity-Checking Slave

This block is the serial front end of a register-access diagnostic mode. A host sends one 16-bit command per chip-select window, in SPI mode 0 with the most significant bit first. While that frame is being sent, the slave returns the response that the previous complete frame produced.

Each complete frame is decoded from its five-bit opcode in D15..D11. The commands set or report a register pointer, write or read the register that the pointer selects, return an acceleration sample, or enter the diagnostic mode. Parity coverage depends on the command class:

- Read-class commands cover only the opcode plus the parity bit in D10.
- Write-class commands cover the whole word, with the parity bit in D9.
- The mode-entry command is not checked.

A parity error has three effects. The bad command is dropped. The command after it is also dropped. The frame after the bad one returns a fault word.

The serial pins are synchronised into the system clock domain and oversampled, so SCLK must be much slower than `clk`. Register accesses are issued on a one-cycle strobe bus with a combinational read-back.

Top module: `spi_parity_slave`

## Requirements
- R1: MOSI is sampled on rising SCLK and MISO changes after falling SCLK, MSB first. The first response bit is on MISO before the first rising edge of the frame. MISO is held low while CS_N is high.
- R2: Read-class opcodes are 5'b10001 (pointer read), 5'b10011 (data read) and 5'b10100 (acceleration read). For these, the XOR of D15..D10 must be 1. D9..D0 do not affect the check.
- R3: Write-class opcodes are 5'b10000 (pointer write) and 5'b10010 (data write). For these, the XOR of all 16 command bits must be 1, and the host sets D9 to achieve this.
- R4: Mode entry (opcode 5'b11111) is never parity-checked. Its response is the constant ENTRY_WORD (default 16'hF0F0), sent unaltered.
- R5: A command that fails its parity check is not executed. The next frame returns 16'h8000.
- R6: The complete frame after a parity failure is ignored whatever it holds. It causes no register access, and its response is the idle word 16'h0001.
- R7: Every response other than ENTRY_WORD has an odd number of ones. The layout of a normal response is:
  - D15 = 0
  - D14..D11 = opcode bits 3..0
  - D10..D1 = zero-extended payload
  - D0 = parity
- R8: Pointer write loads the pointer from D7..D0 and echoes it as payload. Pointer read returns the pointer as payload.
- R9: Data write pulses reg_wr_stb for one cycle, with reg_addr set to the pointer and reg_wdata set to D7..D0, and echoes the data. Data read pulses reg_rd_stb for one cycle and returns reg_rdata as payload. The two strobes are never high together.
- R10: Acceleration read returns accel_sample, captured when the frame ends, as payload.
- R11: A frame with other than 16 rising SCLK edges is discarded. It makes no register access and leaves the pending response and the skip state unchanged.
- R12: After reset:
  - MISO is low.
  - No strobe is active.
  - The pointer is zero.
  - The first response is 16'h0001.
- R13: Any other opcode makes no register access and yields the idle response 16'h0001.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock, idle low |
| cs_n | input | 1 | Active-low chip select, one frame per window |
| mosi | input | 1 | Serial command data from host |
| miso | output | 1 | Serial response data to host |
| reg_addr | output | ADDR_W | Register address, equal to the pointer |
| reg_wdata | output | DATA_W | Register write data |
| reg_wr_stb | output | 1 | One-cycle register write strobe |
| reg_rd_stb | output | 1 | One-cycle register read strobe |
| reg_rdata | input | DATA_W | Register read data, valid while reg_rd_stb is high |
| accel_sample | input | ACC_W | Current acceleration sample |

## Verification
The hardest state to reach from the pins is a skipped frame whose content would itself have been an error, a write or a short frame. Checking it needs a parity failure, then a chosen follow-up frame, then a third frame that shows the result. The stimulus builds commands with deliberately flipped parity bits. It places data writes, further bad commands and truncated frames directly after them. The random phase then mixes corrupted and truncated frames at a high rate, so that these sequences recur with many payloads. Skipped writes are confirmed absent through the strobe count and through a later data read of the same register.

// File: rtl/spi_par_pkg.sv
package spi_par_pkg;

  localparam int FRAME_W = 16;
  localparam int PAY_W   = 10;

  localparam logic [4:0] OP_PTR_WR = 5'b10000;
  localparam logic [4:0] OP_PTR_RD = 5'b10001;
  localparam logic [4:0] OP_DAT_WR = 5'b10010;
  localparam logic [4:0] OP_DAT_RD = 5'b10011;
  localparam logic [4:0] OP_ACC_RD = 5'b10100;
  localparam logic [4:0] OP_ENTER  = 5'b11111;

  localparam logic [15:0] RSP_FAULT = 16'h8000;
  localparam logic [15:0] RSP_IDLE  = 16'h0001;

  // append a bit that makes the total count of ones odd
  function automatic logic [15:0] seal(input logic [14:0] body);
    return {body, ~(^body)};
  endfunction

  function automatic logic [15:0] pack_rsp(input logic [4:0] op,
                                           input logic [PAY_W-1:0] pay);
    return seal({1'b0, op[3:0], pay});
  endfunction

  function automatic logic is_read_op(input logic [4:0] op);
    return (op == OP_PTR_RD) || (op == OP_DAT_RD) || (op == OP_ACC_RD);
  endfunction

  function automatic logic is_write_op(input logic [4:0] op);
    return (op == OP_PTR_WR) || (op == OP_DAT_WR);
  endfunction

endpackage

// File: rtl/spi_par_sync.sv
module spi_par_sync #(
  parameter int               WIDTH   = 1,
  parameter int               STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[s] <= RST_VAL;
        else        stg_q[s] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[s] <= RST_VAL;
        else        stg_q[s] <= stg_q[s-1];
      end
    end
  end

  assign q = stg_q[STAGES-1];

endmodule

// File: rtl/spi_par_link.sv
module spi_par_link #(
  parameter int FRAME_W = 16,
  localparam int CNT_W  = $clog2(FRAME_W + 2)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sclk_s,
  input  logic               cs_n_s,
  input  logic               mosi_s,
  input  logic [FRAME_W-1:0] tx_word,
  output logic               miso,
  output logic               frame_ok,
  output logic [FRAME_W-1:0] rx_word,
  output logic [CNT_W-1:0]   bit_cnt
);

  localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(FRAME_W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);

  logic               sclk_d_q, cs_d_q;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic [FRAME_W-1:0] rx_q, rx_d;
  logic [FRAME_W-1:0] tx_q, tx_d;
  logic               ok_q, ok_d;

  logic rise, fall, start, stop, active;

  always_comb begin
    active = ~cs_n_s;
    rise   = sclk_s & ~sclk_d_q;
    fall   = ~sclk_s & sclk_d_q;
    start  = cs_d_q & ~cs_n_s;
    stop   = ~cs_d_q & cs_n_s;
  end

  always_comb begin
    cnt_d = cnt_q;
    rx_d  = rx_q;
    tx_d  = tx_q;
    if (start) begin
      cnt_d = '0;
      tx_d  = tx_word;
    end else if (active) begin
      if (rise) begin
        rx_d = {rx_q[FRAME_W-2:0], mosi_s};
        if (cnt_q != CNT_MAX) cnt_d = cnt_q + 1'b1;
      end
      if (fall) tx_d = {tx_q[FRAME_W-2:0], 1'b0};
    end
    ok_d = stop && (cnt_q == CNT_FULL);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d_q <= 1'b0;
      cs_d_q   <= 1'b1;
      cnt_q    <= '0;
      rx_q     <= '0;
      tx_q     <= '0;
      ok_q     <= 1'b0;
    end else begin
      sclk_d_q <= sclk_s;
      cs_d_q   <= cs_n_s;
      cnt_q    <= cnt_d;
      rx_q     <= rx_d;
      tx_q     <= tx_d;
      ok_q     <= ok_d;
    end
  end

  assign miso     = active & tx_q[FRAME_W-1];
  assign frame_ok = ok_q;
  assign rx_word  = rx_q;
  assign bit_cnt  = cnt_q;

endmodule

// File: rtl/spi_par_cmd.sv
module spi_par_cmd
  import spi_par_pkg::*;
#(
  parameter int          ADDR_W     = 8,
  parameter int          DATA_W     = 8,
  parameter int          ACC_W      = 10,
  parameter logic [15:0] ENTRY_WORD = 16'hF0F0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_ok,
  input  logic [15:0]       cmd,
  input  logic [DATA_W-1:0] reg_rdata,
  input  logic [ACC_W-1:0]  accel_sample,
  output logic [ADDR_W-1:0] reg_addr,
  output logic [DATA_W-1:0] reg_wdata,
  output logic              reg_wr_stb,
  output logic              reg_rd_stb,
  output logic [15:0]       rsp_word,
  output logic              skip_pend
);

  logic [ADDR_W-1:0] ptr_q, ptr_d;
  logic              skip_q, skip_d;
  logic [15:0]       rsp_q, rsp_d;

  logic [4:0] op;
  logic       rd_cls, wr_cls, par_ok, act, perr, exec;

  always_comb begin
    op     = cmd[15:11];
    rd_cls = is_read_op(op);
    wr_cls = is_write_op(op);
    if (rd_cls)      par_ok = ^cmd[15:10];
    else if (wr_cls) par_ok = ^cmd;
    else             par_ok = 1'b1;
    act  = frame_ok & ~skip_q;
    perr = act & (rd_cls | wr_cls) & ~par_ok;
    exec = act & ~perr;
  end

  always_comb begin
    ptr_d  = ptr_q;
    skip_d = skip_q;
    rsp_d  = rsp_q;
    if (frame_ok) begin
      if (skip_q) begin
        skip_d = 1'b0;
        rsp_d  = RSP_IDLE;
      end else if (perr) begin
        skip_d = 1'b1;
        rsp_d  = RSP_FAULT;
      end else begin
        case (op)
          OP_PTR_WR: begin
            ptr_d = cmd[ADDR_W-1:0];
            rsp_d = pack_rsp(op, PAY_W'(cmd[ADDR_W-1:0]));
          end
          OP_PTR_RD: rsp_d = pack_rsp(op, PAY_W'(ptr_q));
          OP_DAT_WR: rsp_d = pack_rsp(op, PAY_W'(cmd[DATA_W-1:0]));
          OP_DAT_RD: rsp_d = pack_rsp(op, PAY_W'(reg_rdata));
          OP_ACC_RD: rsp_d = pack_rsp(op, PAY_W'(accel_sample));
          OP_ENTER:  rsp_d = ENTRY_WORD;
          default:   rsp_d = RSP_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      skip_q <= 1'b0;
      rsp_q  <= RSP_IDLE;
    end else begin
      ptr_q  <= ptr_d;
      skip_q <= skip_d;
      rsp_q  <= rsp_d;
    end
  end

  assign reg_addr   = ptr_q;
  assign reg_wdata  = cmd[DATA_W-1:0];
  assign reg_wr_stb = exec & (op == OP_DAT_WR);
  assign reg_rd_stb = exec & (op == OP_DAT_RD);
  assign rsp_word   = rsp_q;
  assign skip_pend  = skip_q;

endmodule

// File: rtl/spi_parity_slave.sv
module spi_parity_slave
  import spi_par_pkg::*;
#(
  parameter int          ADDR_W      = 8,
  parameter int          DATA_W      = 8,
  parameter int          ACC_W       = 10,
  parameter int          SYNC_STAGES = 2,
  parameter logic [15:0] ENTRY_WORD  = 16'hF0F0,
  localparam int         CNT_W       = $clog2(FRAME_W + 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk,
  input  logic              cs_n,
  input  logic              mosi,
  output logic              miso,
  output logic [ADDR_W-1:0] reg_addr,
  output logic [DATA_W-1:0] reg_wdata,
  output logic              reg_wr_stb,
  output logic              reg_rd_stb,
  input  logic [DATA_W-1:0] reg_rdata,
  input  logic [ACC_W-1:0]  accel_sample
);

  logic               rst_sync_n;
  logic [2:0]         pins_s;
  logic               frame_ok;
  logic [FRAME_W-1:0] rx_word;
  logic [15:0]        rsp_word;
  logic               skip_pend;
  logic [CNT_W-1:0]   bit_cnt;

  spi_par_sync #(.WIDTH(1), .STAGES(2), .RST_VAL(1'b0)) u_rst_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (1'b1),
    .q     (rst_sync_n)
  );

  // pin order: {cs_n, sclk, mosi}; chip select idles high
  spi_par_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_pin_sync (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .d     ({cs_n, sclk, mosi}),
    .q     (pins_s)
  );

  spi_par_link #(.FRAME_W(FRAME_W)) u_link (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .sclk_s   (pins_s[1]),
    .cs_n_s   (pins_s[2]),
    .mosi_s   (pins_s[0]),
    .tx_word  (rsp_word),
    .miso     (miso),
    .frame_ok (frame_ok),
    .rx_word  (rx_word),
    .bit_cnt  (bit_cnt)
  );

  spi_par_cmd #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .ACC_W      (ACC_W),
    .ENTRY_WORD (ENTRY_WORD)
  ) u_cmd (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .frame_ok     (frame_ok),
    .cmd          (rx_word),
    .reg_rdata    (reg_rdata),
    .accel_sample (accel_sample),
    .reg_addr     (reg_addr),
    .reg_wdata    (reg_wdata),
    .reg_wr_stb   (reg_wr_stb),
    .reg_rd_stb   (reg_rd_stb),
    .rsp_word     (rsp_word),
    .skip_pend    (skip_pend)
  );

endmodule

// File: rtl/spi_parity_slave_chk.sv
module spi_parity_slave_chk
  import spi_par_pkg::*;
#(
  parameter logic [15:0] ENTRY_WORD = 16'hF0F0,
  parameter int          CNT_W      = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             frame_ok,
  input logic             skip,
  input logic [15:0]      rsp_word,
  input logic [CNT_W-1:0] bit_cnt,
  input logic             reg_wr_stb,
  input logic             reg_rd_stb
);

  AST_STB_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({reg_wr_stb, reg_rd_stb})); // R9

  AST_STB_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_stb || reg_rd_stb) |=> !(reg_wr_stb || reg_rd_stb)); // R9

  AST_STB_NEEDS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_stb || reg_rd_stb) |-> frame_ok); // R11

  AST_SKIP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (skip && frame_ok) |-> !(reg_wr_stb || reg_rd_stb)); // R6

  AST_SKIP_IDLE_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    (skip && frame_ok) |=> (!skip && rsp_word == RSP_IDLE)); // R6

  AST_FAULT_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(skip) |-> (rsp_word == RSP_FAULT)); // R5

  AST_RSP_ODD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_word != ENTRY_WORD) |-> (^rsp_word)); // R7

  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_ok |=> $stable(rsp_word)); // R11

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt <= CNT_W'(FRAME_W + 1)); // R11

endmodule

bind spi_parity_slave spi_parity_slave_chk #(
  .ENTRY_WORD (ENTRY_WORD),
  .CNT_W      (CNT_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .frame_ok   (frame_ok),
  .skip       (skip_pend),
  .rsp_word   (rsp_word),
  .bit_cnt    (bit_cnt),
  .reg_wr_stb (reg_wr_stb),
  .reg_rd_stb (reg_rd_stb)
);

// File: tb/spi_parity_slave_bench.sv
module spi_parity_slave_bench;

  localparam logic [15:0] ENTRY = 16'hF0F0;
  localparam logic [15:0] FAULT = 16'h8000;
  localparam logic [15:0] IDLE  = 16'h0001;
  localparam logic [4:0]  PW = 5'b10000, PR = 5'b10001, DW = 5'b10010,
                          DR = 5'b10011, AR = 5'b10100, EN = 5'b11111;
  localparam int HALF = 8;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst_n, sclk, cs_n, mosi, miso;
  logic [7:0] reg_addr, reg_wdata, reg_rdata;
  logic       reg_wr_stb, reg_rd_stb;
  logic [9:0] accel;

  spi_parity_slave u_spi_parity_slave (
    .clk          (clk),
    .rst_n        (rst_n),
    .sclk         (sclk),
    .cs_n         (cs_n),
    .mosi         (mosi),
    .miso         (miso),
    .reg_addr     (reg_addr),
    .reg_wdata    (reg_wdata),
    .reg_wr_stb   (reg_wr_stb),
    .reg_rd_stb   (reg_rd_stb),
    .reg_rdata    (reg_rdata),
    .accel_sample (accel)
  );

  // bench register file with strobe counters
  logic [7:0] mem [256];
  int s_wr, s_rd;
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] <= 8'(i * 7 + 3);
      s_wr <= 0;
      s_rd <= 0;
    end else begin
      if (reg_wr_stb) begin
        mem[reg_addr] <= reg_wdata;
        s_wr <= s_wr + 1;
      end
      if (reg_rd_stb) s_rd <= s_rd + 1;
    end
  end
  assign reg_rdata = mem[reg_addr];

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req,
                     input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // reference model
  logic [15:0] m_rsp;
  logic [7:0]  m_ptr;
  bit          m_skip;
  logic [7:0]  shadow [256];
  int          m_wr, m_rd;

  function automatic logic [15:0] seal15(input logic [14:0] b);
    return {b, ~(^b)};
  endfunction

  function automatic logic [15:0] rsp_of(input logic [4:0] op, input logic [9:0] pay);
    return seal15({1'b0, op[3:0], pay});
  endfunction

  function automatic logic [15:0] mk_read(input logic [4:0] op, input logic [9:0] low, input bit bad);
    logic [15:0] w;
    w = {op, 1'b0, low};
    w[10] = ~(^w[15:11]) ^ bad;
    return w;
  endfunction

  function automatic logic [15:0] mk_write(input logic [4:0] op, input logic [10:0] low, input bit bad);
    logic [15:0] w;
    w = {op, low};
    w[9] = 1'b0;
    w[9] = ~(^w) ^ bad;
    return w;
  endfunction

  task automatic model(input logic [15:0] cmd);
    logic [4:0] op;
    bit rd_ok, wr_ok;
    op = cmd[15:11];
    rd_ok = ^cmd[15:10];
    wr_ok = ^cmd;
    if (m_skip) begin
      m_skip = 0;
      m_rsp = IDLE;
    end else if (((op == PR) || (op == DR) || (op == AR)) && !rd_ok) begin
      m_skip = 1;
      m_rsp = FAULT;
    end else if (((op == PW) || (op == DW)) && !wr_ok) begin
      m_skip = 1;
      m_rsp = FAULT;
    end else begin
      case (op)
        PW: begin m_ptr = cmd[7:0]; m_rsp = rsp_of(op, {2'b0, cmd[7:0]}); end
        PR: m_rsp = rsp_of(op, {2'b0, m_ptr});
        DW: begin shadow[m_ptr] = cmd[7:0]; m_wr++; m_rsp = rsp_of(op, {2'b0, cmd[7:0]}); end
        DR: begin m_rd++; m_rsp = rsp_of(op, {2'b0, shadow[m_ptr]}); end
        AR: m_rsp = rsp_of(op, accel);
        EN: m_rsp = ENTRY;
        default: m_rsp = IDLE;
      endcase
    end
  endtask

  task automatic xfer(input logic [15:0] cmd, input int nbits, output logic [15:0] rsp);
    rsp = '0;
    cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      mosi = cmd[15-i];
      repeat (HALF) @(negedge clk);
      rsp[15-i] = miso;
      sclk = 1'b1;
      repeat (HALF) @(negedge clk);
      sclk = 1'b0;
    end
    repeat (HALF) @(negedge clk);
    cs_n = 1'b1;
    mosi = 1'b0;
    repeat (12) @(negedge clk);
  endtask

  task automatic frame(input logic [15:0] cmd, input int nbits, input string req);
    logic [15:0] rsp;
    xfer(cmd, nbits, rsp);
    if (nbits == 16) begin
      chk(rsp === m_rsp, req, rsp, m_rsp);
      if (rsp !== ENTRY) chk(^rsp === 1'b1, "R7", rsp, m_rsp);
      model(cmd);
    end
    chk((s_wr == m_wr) && (s_rd == m_rd), req, 16'(s_wr * 256 + s_rd), 16'(m_wr * 256 + m_rd));
    chk(miso === 1'b0, "R1", {15'd0, miso}, 16'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%h expected=%h", 16'd1, 16'd0);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1357));
    rst_n = 1'b0; sclk = 1'b0; cs_n = 1'b1; mosi = 1'b0; accel = 10'h2A7;
    for (int i = 0; i < 256; i++) shadow[i] = 8'(i * 7 + 3);
    m_rsp = IDLE; m_ptr = 8'h00; m_skip = 0; m_wr = 0; m_rd = 0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (8) @(negedge clk);

    chk(miso === 1'b0 && !reg_wr_stb && !reg_rd_stb, "R12",
        {13'd0, miso, reg_wr_stb, reg_rd_stb}, 16'd0);
    frame(mk_read(PR, 10'h3FF, 0), 16, "R12");       // returns idle; next gives ptr 0
    frame(mk_read(DR, 10'h000, 0), 16, "R8");        // pointer read at reset: 0
    frame(mk_write(PW, 11'h03C, 0), 16, "R9");       // data read response of reg 0
    frame(mk_read(PR, 10'h155, 0), 16, "R3");        // pointer write echo
    frame(mk_write(DW, 11'h05A, 0), 16, "R8");       // pointer read = 3C
    frame(mk_read(DR, 10'h000, 0), 16, "R9");        // data write echo
    frame(mk_read(AR, 10'h2AA, 0), 16, "R9");        // data read of 5A
    frame(16'hFFFF, 16, "R10");                      // accel response
    frame(16'hF800, 16, "R4");                       // entry response, odd-looking input
    frame(mk_read(DR, 10'h000, 1), 16, "R4");        // bad read parity
    frame(mk_write(DW, 11'h0C3, 0), 16, "R5");       // fault returned; write skipped
    frame(mk_read(DR, 10'h000, 0), 16, "R6");        // idle after skip
    frame(mk_read(PR, 10'h000, 0), 16, "R6");        // reg 3C still 5A
    frame(mk_write(PW, 11'h011, 1), 16, "R2");       // bad write parity
    frame(mk_write(DW, 11'h0EE, 1), 16, "R3");       // fault; bad follow-up skipped anyway
    frame(mk_write(DW, 11'h077, 0), 16, "R6");       // idle; good write executes
    frame(mk_write(DW, 11'h099, 0), 9, "R11");       // short frame discarded
    frame(16'b00101_00000000000, 16, "R11");         // response still data-write echo
    frame(mk_read(PR, 10'h000, 0), 16, "R13");       // unknown op gives idle
    frame(mk_read(PR, 10'h000, 1), 16, "R8");
    frame(mk_write(PW, 11'h044, 0), 5, "R11");       // short frame during skip: kept
    frame(mk_write(PW, 11'h044, 0), 16, "R5");       // skipped
    frame(mk_read(PR, 10'h000, 0), 16, "R6");        // ptr unchanged, idle

    for (int n = 0; n < 250; n++) begin
      logic [4:0] op;
      int pick, nb;
      bit bad;
      logic [15:0] c;
      pick = $urandom_range(0, 7);
      case (pick)
        0: op = PW; 1: op = PR; 2: op = DW; 3: op = DR;
        4: op = AR; 5: op = EN; 6: op = 5'(($urandom_range(0, 15)));
        default: op = DR;
      endcase
      bad = ($urandom_range(0, 99) < 15);
      if (pick == 0) c = mk_write(op, 11'($urandom_range(0, 7)) | 11'h000, bad);
      else if (pick == 2) c = mk_write(op, 11'($urandom), bad);
      else if (pick == 5) c = {op, 11'($urandom)};
      else c = mk_read(op, 10'($urandom), bad);
      nb = ($urandom_range(0, 99) < 8) ? $urandom_range(1, 15) : 16;
      accel = 10'($urandom);
      frame(c, nb, "R7");
    end

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule